// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Clear-to-Send Gating

This block is a clock-synchronous serial transmitter that acts as the clock master. It makes its own serial clock from a programmable divider and shifts out frames of `DATA_W` bits, least significant bit first. Software writes a byte into a single holding buffer. The byte moves into the shift register only at a frame boundary, and only when a new frame is allowed to start. Because of this double buffering, the next byte can be written while the current one is still shifting.

The start conditions are a transmit enable input and, when the clear-to-send option is switched on, an active-low clear-to-send input. They are evaluated only at the frame boundary. That boundary is either any cycle in which the transmitter is idle, or the cycle that ends the high half of the last bit. Changing the conditions in the middle of a frame therefore never cuts that frame short. The block reports two flags, holding buffer empty and shift register empty. It also raises a transmit interrupt request each time the buffer hands a byte to the shift register.

Top module: `sync_ser_tx`

## Requirements
- R1: Synchronous active-high reset drives `sclk` high and `sdata` high, sets `buf_empty` and `reg_empty`, and clears `tx_irq`. While idle, `sclk` and `sdata` stay high.
- R2: Each half of the serial clock lasts `div_val`+1 clock cycles, so one bit period is 2(`div_val`+1) cycles. A frame starts with `sclk` going low.
- R3: Bits leave least significant first. `sdata` changes only together with a falling `sclk` and stays stable while `sclk` is high.
- R4: A write (`wr_stb`) clears `buf_empty` one cycle later. When the byte is moved into the shift register, `buf_empty` goes to 1 and `reg_empty` goes to 0 in the same cycle, and `sclk` goes low.
- R5: Start conditions are evaluated only while idle or in the cycle that ends the final high half. Dropping `tx_en` in the middle of a frame lets that frame complete.
- R6: If `tx_en` is 0 at the evaluation point, no frame starts, even with a byte pending. `sclk` stays high.
- R7: With `cts_use`=1 and `cts_n`=1 at the evaluation point, no frame starts. A pending frame starts once `cts_n` is 0.
- R8: With `cts_use`=0, `cts_n` has no effect, and a pending byte follows the previous frame with no idle cycle in between.
- R9: `tx_irq` is set in the cycle a byte is loaded. It is cleared by `irq_ack` or `irq_clr`, and a load in the same cycle wins over a clear.
- R10: At the end of a frame with no byte loaded, `reg_empty` rises and `sclk`/`sdata` return high.
- R11: A write while the buffer is full replaces the pending byte. Only the last written byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the divider count source |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Divider setting n, giving half period n+1 |
| tx_en | input | 1 | Transmit enable |
| cts_use | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to write |
| irq_ack | input | 1 | Interrupt accepted pulse |
| irq_clr | input | 1 | Software clear of the interrupt request |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data |
| buf_empty | output | 1 | Holding buffer empty flag |
| reg_empty | output | 1 | Shift register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench probes the following corner cases:
- **Mid-frame disable.** `tx_en` is dropped while a frame is shifting. A design that sampled it continuously would truncate the frame, or would fail to stop before the byte that is waiting.
- **Clear-to-send.** It is held inactive both with gating on and with gating off. A design that ignored the option bit would either start against the flag or stall when it should run.
- **Back-to-back frames.** The bench measures the cycle count of two queued frames at the smallest divider setting, which exposes an idle gap at the boundary.
- **Overwrite while full.** This shows whether a stale byte leaks out.
- **Interrupt clear paths.** A flag that clears on only one of the two inputs stays set.

// File: rtl/sst_pkg.sv
package sst_pkg;
   typedef enum logic {
      HALF_LOW  = 1'b0,
      HALF_HIGH = 1'b1
   } half_e;
endpackage

// File: rtl/sst_baud_div.sv
module sst_baud_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= div_val);

   always_ff @(posedge clk) begin
      if (rst || !run || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // half-period counter never passes the setting while it is stable
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
      (run && $past(run) && $stable(div_val)) |-> (cnt_q <= div_val));
endmodule

// File: rtl/sst_hold_buf.sv
module sst_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] data,
   output logic              full
);
   always_ff @(posedge clk) begin
      if (rst) begin
         data <= '0;
         full <= 1'b0;
      end else begin
         if (take) full <= 1'b0;
         if (wr_stb) begin
            data <= wr_data;
            full <= 1'b1;
         end
      end
   end

   assert_take_empties_R4: assert property (@(posedge clk) disable iff (rst)
      (take && !wr_stb) |=> !full);
   assert_write_replaces_R11: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> (full && data == $past(wr_data)));
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
   import sst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              busy,
   output logic              frame_done,
   output logic              sclk,
   output logic              sdata
);
   localparam int HALVES = 2 * DATA_W;
   localparam int HW = $clog2(HALVES);
   localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

   logic [HW-1:0]     half_q;
   logic [DATA_W-1:0] shreg_q;

   assign frame_done = busy && tick && (half_q == LAST_HALF);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         half_q  <= '0;
         shreg_q <= '0;
         sclk    <= 1'b1;
         sdata   <= 1'b1;
      end else if (load) begin
         busy    <= 1'b1;
         half_q  <= '0;
         shreg_q <= load_data;
         sclk    <= 1'b0;
         sdata   <= load_data[0];
      end else if (frame_done) begin
         busy    <= 1'b0;
         half_q  <= '0;
         sclk    <= 1'b1;
         sdata   <= 1'b1;
      end else if (busy && tick) begin
         half_q <= half_q + 1'b1;
         if (half_e'(half_q[0]) == HALF_LOW) begin
            sclk <= 1'b1;
         end else begin
            sclk    <= 1'b0;
            shreg_q <= shreg_q >> 1;
            sdata   <= shreg_q[1];
         end
      end
   end

   assert_sdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(sdata));
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (sclk && sdata));
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter bit CTS_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              tx_en,
   input  logic              cts_use,
   input  logic              cts_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_ack,
   input  logic              irq_clr,
   output logic              sclk,
   output logic              sdata,
   output logic              buf_empty,
   output logic              reg_empty,
   output logic              tx_irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_ser_tx: DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sync_ser_tx: DIV_W must be at least 1");
      end
   endgenerate

   logic              tick, busy, frame_done, load, cts_ok, buf_full;
   logic [DATA_W-1:0] buf_data;

   generate
      if (CTS_PRESENT) begin : g_cts
         assign cts_ok = !cts_use || !cts_n;
      end else begin : g_no_cts
         assign cts_ok = 1'b1;
      end
   endgenerate

   // evaluation point: idle, or end of the final high half
   assign load = (!busy || frame_done) && buf_full && tx_en && cts_ok;

   sst_baud_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .run(busy), .div_val(div_val), .tick(tick)
   );

   sst_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
      .take(load), .data(buf_data), .full(buf_full)
   );

   sst_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst(rst), .tick(tick), .load(load), .load_data(buf_data),
      .busy(busy), .frame_done(frame_done), .sclk(sclk), .sdata(sdata)
   );

   assign buf_empty = !buf_full;

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_empty <= 1'b1;
         tx_irq    <= 1'b0;
      end else begin
         if (load)            reg_empty <= 1'b0;
         else if (frame_done) reg_empty <= 1'b1;
         if (load)                    tx_irq <= 1'b1;
         else if (irq_ack || irq_clr) tx_irq <= 1'b0;
      end
   end

   assert_irq_on_load_R9: assert property (@(posedge clk) disable iff (rst)
      load |=> tx_irq);
   assert_empty_at_end_R10: assert property (@(posedge clk) disable iff (rst)
      (frame_done && !load) |=> (reg_empty && !busy));
   assert_disabled_stays_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (!busy && !tx_en) |=> !busy);
   assert_frame_not_cut_R5: assert property (@(posedge clk) disable iff (rst)
      (busy && !frame_done) |=> (busy && !reg_empty));

   generate
      if (CTS_PRESENT) begin : g_cts_chk
         assert_cts_holds_R7: assert property (@(posedge clk) disable iff (rst)
            (!busy && cts_use && cts_n) |=> !busy);
      end
   endgenerate
endmodule

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
   localparam int DATA_W = 8;
   localparam int DIV_W  = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst = 1'b1;
   logic [DIV_W-1:0]  div_val = '0;
   logic              tx_en = 1'b0, cts_use = 1'b0, cts_n = 1'b0;
   logic              wr_stb = 1'b0, irq_ack = 1'b0, irq_clr = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              sclk, sdata, buf_empty, reg_empty, tx_irq;

   sync_ser_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_sync_ser_tx (
      .clk(clk), .rst(rst), .div_val(div_val), .tx_en(tx_en),
      .cts_use(cts_use), .cts_n(cts_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .irq_ack(irq_ack), .irq_clr(irq_clr), .sclk(sclk), .sdata(sdata),
      .buf_empty(buf_empty), .reg_empty(reg_empty), .tx_irq(tx_irq)
   );

   int n_checks = 0, n_errors = 0;
   bit active = 1'b0, done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_cnt = 0, m_half = 0;
   bit m_busy = 0, m_full = 0, m_irq = 0, m_regemp = 1;
   logic [DATA_W-1:0] m_buf = '0, m_word = '0;
   logic [DATA_W-1:0] exp_q[$];

   always @(posedge clk) begin : model
      bit tk, fend, ok, ld;
      if (rst) begin
         m_cnt = 0; m_half = 0; m_busy = 0; m_full = 0; m_irq = 0; m_regemp = 1;
      end else begin
         tk   = m_busy && (m_cnt >= int'(div_val));
         fend = !m_busy || (tk && m_half == 2 * DATA_W - 1);
         ok   = m_full && tx_en && (!cts_use || !cts_n);
         ld   = fend && ok;
         if (ld) begin
            m_busy = 1; m_word = m_buf; m_half = 0; m_cnt = 0;
            m_full = 0; m_regemp = 0; exp_q.push_back(m_buf);
         end else if (fend) begin
            m_busy = 0; m_half = 0; m_cnt = 0; m_regemp = 1;
         end else if (tk) begin
            m_cnt = 0; m_half++;
         end else begin
            m_cnt++;
         end
         if (ld) m_irq = 1;
         else if (irq_ack || irq_clr) m_irq = 0;
         if (wr_stb) begin m_buf = wr_data; m_full = 1; end
      end
   end

   // per-cycle comparison and serial receiver
   logic prev_sclk = 1'b1;
   logic [DATA_W-1:0] rx_sh = '0, last_rx = '0;
   int rx_n = 0;

   always @(negedge clk) begin
      if (active) begin
         check(sclk === (m_busy ? m_half[0] : 1'b1), "R2 sclk", sclk, m_busy ? m_half[0] : 1);
         check(sdata === (m_busy ? m_word[m_half / 2] : 1'b1), "R3 sdata", sdata,
               m_busy ? m_word[m_half / 2] : 1);
         check(buf_empty === !m_full, "R4 buf_empty", buf_empty, !m_full);
         check(reg_empty === m_regemp, "R10 reg_empty", reg_empty, m_regemp);
         check(tx_irq === m_irq, "R9 tx_irq", tx_irq, m_irq);
         if (!prev_sclk && sclk) begin
            rx_sh = {sdata, rx_sh[DATA_W-1:1]};
            rx_n++;
            if (rx_n == DATA_W) begin
               rx_n = 0;
               last_rx = rx_sh;
               if (exp_q.size() == 0) check(1'b0, "R3 frame", rx_sh, 0);
               else begin
                  logic [DATA_W-1:0] e;
                  e = exp_q.pop_front();
                  check(rx_sh == e, "R3 frame", rx_sh, e);
               end
            end
         end
         prev_sclk = sclk;
      end
   end

   task automatic write_byte(input logic [DATA_W-1:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         if (buf_empty && reg_empty) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_low();
      for (int i = 0; i < 200; i++) begin
         if (!sclk) break;
         @(negedge clk);
      end
   endtask

   initial begin : stim
      int n;
      wait_cycles(3);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset / idle state
      check(sclk && sdata, "R1 idle lines", {sclk, sdata}, 3);
      check(buf_empty && reg_empty, "R1 flags", {buf_empty, reg_empty}, 3);
      check(!tx_irq, "R1 irq", tx_irq, 0);
      active = 1'b1;

      // R2 / R4 / R9 single frame, divider 2
      div_val = 8'd2; tx_en = 1'b1;
      write_byte(8'hA5);
      wait_low();
      check(buf_empty && !reg_empty, "R4 load flags", {buf_empty, reg_empty}, 2);
      check(tx_irq, "R9 set on load", tx_irq, 1);
      n = 0;
      while (!sclk && n < 50) begin n++; @(negedge clk); end
      check(n == 3, "R2 low half", n, 3);
      n = 0;
      while (sclk && n < 50) begin n++; @(negedge clk); end
      check(n == 3, "R2 high half", n, 3);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      check(!tx_irq, "R9 ack clears", tx_irq, 0);
      wait_idle();
      check(sclk && sdata && reg_empty, "R10 end of frame", {sclk, sdata, reg_empty}, 7);
      check(last_rx == 8'hA5, "R3 lsb first", last_rx, 8'hA5);

      // R8 back-to-back, CTS ignored when option off
      div_val = 8'd0; cts_use = 1'b0; cts_n = 1'b1;
      write_byte(8'h3C);
      wait_low();
      wr_stb = 1'b1; wr_data = 8'hC3;
      n = 0;
      while (!reg_empty && n < 200) begin
         n++;
         @(negedge clk);
         wr_stb = 1'b0;
      end
      check(n == 32, "R8 no gap", n, 32);
      check(last_rx == 8'hC3, "R8 second frame", last_rx, 8'hC3);
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      check(!tx_irq, "R9 clr clears", tx_irq, 0);
      cts_n = 1'b0;

      // R11 overwrite, R6 disabled start
      tx_en = 1'b0;
      write_byte(8'h11);
      write_byte(8'h22);
      wait_cycles(20);
      check(sclk && reg_empty && !buf_empty, "R6 held", {sclk, reg_empty, buf_empty}, 6);
      tx_en = 1'b1;
      wait_cycles(1);
      wait_idle();
      check(last_rx == 8'h22, "R11 overwrite", last_rx, 8'h22);

      // R5 mid-frame disable
      div_val = 8'd1;
      write_byte(8'h5A);
      wait_low();
      write_byte(8'h77);
      tx_en = 1'b0;
      wait_cycles(50);
      check(last_rx == 8'h5A, "R5 frame completes", last_rx, 8'h5A);
      check(sclk && reg_empty && !buf_empty, "R5 next held", {sclk, reg_empty, buf_empty}, 6);
      tx_en = 1'b1;
      wait_cycles(1);
      wait_idle();
      check(last_rx == 8'h77, "R5 resumes", last_rx, 8'h77);

      // R7 clear-to-send gating
      cts_use = 1'b1; cts_n = 1'b1;
      write_byte(8'h99);
      wait_cycles(20);
      check(sclk && !buf_empty, "R7 held by cts", {sclk, buf_empty}, 2);
      cts_n = 1'b0;
      wait_cycles(1);
      wait_idle();
      check(last_rx == 8'h99, "R7 resumes", last_rx, 8'h99);
      check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

      wait_cycles(5);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule